// File: doc/BRIEF.md
# Three-Wire Serial Clock and NVRAM Slave

This block is the slave end of a three-wire serial link. Software drives the link through register bits: a chip-enable, a serial clock and a data line. The block samples the data line on each falling edge of the serial clock while chip-enable is high. A frame is 16 bits long. The first eight bits form a command byte and the next eight form a value byte, each sent most significant bit first.

The command selects one of several actions. It can read one of 32 bytes of retained memory, read the status or control byte, or read a time field in packed BCD. The time fields come from binary time inputs, since the block holds no oscillator. A command can also write a memory byte, or clear the status flags and send a one-cycle clear pulse to the interrupt logic. Read data is shifted out during the second byte, at the same time as the value byte is shifted in. Writes take effect after the sixteenth bit. Dropping chip-enable at any point abandons the frame.

Top module: `serial_clock_slave`

## Requirements
- R1: A bit is taken only on a high-to-low transition of `sclk_i` seen while `ce_i` is high; clock activity while `ce_i` is low has no effect.
- R2: Bits 0 to 7 of a frame build the command byte and bits 8 to 15 build the value byte, both most significant bit first; bits after the sixteenth are ignored until `ce_i` falls.
- R3: Taking `ce_i` low abandons the frame. The bit count, command and value return to zero, `sdo_o` goes to 0 on the next clock, and a partly sent write changes nothing.
- R4: For commands 0x00 to 0x1F, `sdo_o` presents memory byte [command] during bits 8 to 15. Bit 7 comes first. Each bit is updated on the clock after the falling edge that takes frame bit 8+k, and is held until the next taken edge.
- R5: Command 0x30 reads the status byte and command 0x31 reads the control byte, with the same bit order. The control byte is fixed at 0x00.
- R6: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day, month and year. Each is in packed BCD, with tens in bits 7:4 and units in bits 3:0. The other commands from 0x20 to 0x2F return 0x00.
- R7: After the sixteenth bit, a command from 0x80 to 0x9F writes the value byte into memory byte [command - 0x80].
- R8: After the sixteenth bit, command 0xB1 with value bit 2 set clears status bits 4 and 3 and raises `irq_clr_o` for exactly one clock. With value bit 2 clear, the command does nothing.
- R9: After reset, status is 0x90, `sdo_o` is 0, and memory byte i holds ((i*0x25) mod 256) XOR 0x5A.
- R10: Any command not listed above drives `sdo_o` to 0 for the whole frame and changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Serial chip-enable |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| sdi_i | input | 1 | Serial data from the host |
| sec_i | input | 6 | Seconds, binary 0 to 59 |
| min_i | input | 6 | Minutes, binary 0 to 59 |
| hour_i | input | 5 | Hours, binary 0 to 23 |
| day_i | input | 5 | Day of month, binary 1 to 31 |
| month_i | input | 4 | Month, binary 1 to 12 |
| year_i | input | 7 | Two-digit year, binary 0 to 99 |
| sdo_o | output | 1 | Serial data to the host |
| irq_clr_o | output | 1 | One-cycle interrupt clear pulse |

## Verification
On every cycle the assertions check several properties. With no falling edge, the bit count and `sdo_o` hold still. When chip-enable is low, the frame state and `sdo_o` are zero. The bit count never goes past sixteen, and the clear pulse lasts a single cycle. What the assertions cannot see is whether the bytes are right: memory contents, the BCD conversion, the write address and value, and the clear of the status bits. Only the bench scenarios show these, by reading state back over the serial link and comparing it with a reference model.

// File: rtl/serial_clock_pkg.sv
package serial_clock_pkg;
  localparam int NV_BYTES   = 32;
  localparam int NV_AW      = $clog2(NV_BYTES);
  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 8;
  localparam int PHASE_W    = $clog2(FRAME_BITS + 1);
  localparam int TIME_SLOTS = 8;

  localparam logic [7:0] STATUS_RST   = 8'h90;
  localparam logic [7:0] CTRL_VAL     = 8'h00;
  localparam logic [7:0] NV_SEED      = 8'h5A;
  localparam logic [7:0] NV_STEP      = 8'h25;
  localparam logic [7:0] CMD_STATUS   = 8'h30;
  localparam logic [7:0] CMD_CTRL     = 8'h31;
  localparam logic [7:0] CMD_WR_BASE  = 8'h80;
  localparam logic [7:0] CMD_CLR      = 8'hB1;
  localparam logic [3:0] CMD_TIME_HI  = 4'h2;
  localparam logic [7:0] CLR_REQ_MASK = 8'h04;
  localparam logic [7:0] STATUS_FLAGS = 8'h18;

  function automatic logic [7:0] nv_init(int unsigned idx);
    logic [7:0] prod;
    prod = 8'(idx) * NV_STEP;
    return prod ^ NV_SEED;
  endfunction

  function automatic logic [7:0] to_bcd(logic [6:0] v);
    logic [3:0] tens;
    logic [6:0] rem;
    tens = '0;
    rem  = v;
    for (int k = 0; k < 9; k++) begin
      if (rem >= 7'd10) begin
        rem  = rem - 7'd10;
        tens = tens + 4'd1;
      end
    end
    return {tens, rem[3:0]};
  endfunction
endpackage

// File: rtl/serial_frame_ctl.sv
module serial_frame_ctl
  import serial_clock_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               take_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [7:0]         cmd_o,
  output logic               commit_o,
  output logic [7:0]         commit_val_o
);
  localparam logic [PHASE_W-1:0] LAST_BIT = PHASE_W'(FRAME_BITS - 1);
  localparam logic [PHASE_W-1:0] END_BIT  = PHASE_W'(FRAME_BITS);
  localparam logic [PHASE_W-1:0] CMD_END  = PHASE_W'(CMD_BITS);

  logic               sclk_q;
  logic [PHASE_W-1:0] phase_q;
  logic [7:0]         cmd_q, val_q;
  logic               take;

  // falling edge while selected, frame not yet complete
  assign take = ce_i & sclk_q & ~sclk_i & (phase_q < END_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      phase_q <= '0;
      cmd_q   <= '0;
      val_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (!ce_i) begin
        phase_q <= '0;
        cmd_q   <= '0;
        val_q   <= '0;
      end else if (take) begin
        phase_q <= phase_q + 1'b1;
        if (phase_q < CMD_END) cmd_q <= {cmd_q[6:0], sdi_i};
        else                   val_q <= {val_q[6:0], sdi_i};
      end
    end
  end

  assign take_o       = take;
  assign phase_o      = phase_q;
  assign cmd_o        = cmd_q;
  assign commit_o     = take & (phase_q == LAST_BIT);
  assign commit_val_o = {val_q[6:0], sdi_i};
endmodule

// File: rtl/serial_clock_store.sv
module serial_clock_store
  import serial_clock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] cmd_i,
  input  logic       commit_i,
  input  logic [7:0] commit_val_i,
  output logic [7:0] rd_o,
  output logic       irq_clr_o
);
  logic [7:0] nv_q [NV_BYTES];
  logic [7:0] status_q;
  logic [7:0] wr_off;
  logic       wr_hit, clr_hit, irq_clr_q;

  assign wr_off  = cmd_i - CMD_WR_BASE;
  assign wr_hit  = commit_i && (cmd_i >= CMD_WR_BASE) && (wr_off < 8'(NV_BYTES));
  assign clr_hit = commit_i && (cmd_i == CMD_CLR) && ((commit_val_i & CLR_REQ_MASK) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NV_BYTES; i++) nv_q[i] <= nv_init(i);
    end else if (wr_hit) begin
      nv_q[wr_off[NV_AW-1:0]] <= commit_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= STATUS_RST;
      irq_clr_q <= 1'b0;
    end else begin
      irq_clr_q <= clr_hit;
      if (clr_hit) status_q <= status_q & ~STATUS_FLAGS;
    end
  end

  always_comb begin
    if (cmd_i < 8'(NV_BYTES))   rd_o = nv_q[cmd_i[NV_AW-1:0]];
    else if (cmd_i == CMD_STATUS) rd_o = status_q;
    else if (cmd_i == CMD_CTRL)   rd_o = CTRL_VAL;
    else                          rd_o = '0;
  end

  assign irq_clr_o = irq_clr_q;
endmodule

// File: rtl/serial_clock_time.sv
module serial_clock_time
  import serial_clock_pkg::*;
(
  input  logic [7:0] cmd_i,
  input  logic [5:0] sec_i,
  input  logic [5:0] min_i,
  input  logic [4:0] hour_i,
  input  logic [4:0] day_i,
  input  logic [3:0] month_i,
  input  logic [6:0] year_i,
  output logic [7:0] bcd_o
);
  logic [6:0] field [TIME_SLOTS];
  logic [7:0] bcd   [TIME_SLOTS];

  // slot order follows the low command nibble; slots 3 and 7 read zero
  assign field[0] = 7'(sec_i);
  assign field[1] = 7'(min_i);
  assign field[2] = 7'(hour_i);
  assign field[3] = '0;
  assign field[4] = 7'(day_i);
  assign field[5] = 7'(month_i);
  assign field[6] = year_i;
  assign field[7] = '0;

  for (genvar g = 0; g < TIME_SLOTS; g++) begin : g_bcd
    assign bcd[g] = to_bcd(field[g]);
  end

  assign bcd_o = (cmd_i[7:4] == CMD_TIME_HI && !cmd_i[3]) ? bcd[cmd_i[2:0]] : 8'h00;
endmodule

// File: rtl/serial_clock_slave.sv
module serial_clock_slave
  import serial_clock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic [5:0] sec_i,
  input  logic [5:0] min_i,
  input  logic [4:0] hour_i,
  input  logic [4:0] day_i,
  input  logic [3:0] month_i,
  input  logic [6:0] year_i,
  output logic       sdo_o,
  output logic       irq_clr_o
);
  localparam logic [PHASE_W-1:0] RD_FIRST = PHASE_W'(CMD_BITS);
  localparam logic [PHASE_W-1:0] RD_LAST  = PHASE_W'(FRAME_BITS - 1);

  logic               take_w, commit_w;
  logic [PHASE_W-1:0] phase_w;
  logic [7:0]         cmd_w, commit_val_w, store_rd_w, time_rd_w, rd_byte;
  logic               sdo_q;

  serial_frame_ctl u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ce_i         (ce_i),
    .sclk_i       (sclk_i),
    .sdi_i        (sdi_i),
    .take_o       (take_w),
    .phase_o      (phase_w),
    .cmd_o        (cmd_w),
    .commit_o     (commit_w),
    .commit_val_o (commit_val_w)
  );

  serial_clock_store u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd_w),
    .commit_i     (commit_w),
    .commit_val_i (commit_val_w),
    .rd_o         (store_rd_w),
    .irq_clr_o    (irq_clr_o)
  );

  serial_clock_time u_time (
    .cmd_i   (cmd_w),
    .sec_i   (sec_i),
    .min_i   (min_i),
    .hour_i  (hour_i),
    .day_i   (day_i),
    .month_i (month_i),
    .year_i  (year_i),
    .bcd_o   (time_rd_w)
  );

  // both sources return zero outside their own command range
  assign rd_byte = store_rd_w | time_rd_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sdo_q <= 1'b0;
    else if (!ce_i)             sdo_q <= 1'b0;
    else if (take_w && phase_w >= RD_FIRST && phase_w <= RD_LAST)
                                sdo_q <= rd_byte[~phase_w[2:0]];
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/serial_clock_slave_chk.sv
module serial_clock_slave_chk
  import serial_clock_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ce_i,
  input logic               sclk_i,
  input logic               sdo_o,
  input logic               irq_clr_o,
  input logic [PHASE_W-1:0] phase_i,
  input logic [7:0]         cmd_i
);
  AST_NO_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && $past(ce_i) && !($past(sclk_i) && !sclk_i) |=> $stable(phase_i)); // R1
  AST_PHASE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i <= PHASE_W'(FRAME_BITS)); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (phase_i == '0) && (cmd_i == '0)); // R3
  AST_ABORT_SDO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> !sdo_o); // R3
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !($past(sclk_i) && !sclk_i) |=> $stable(sdo_o)); // R4
  AST_CLR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |=> !irq_clr_o); // R8
  AST_CLR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_clr_o) |-> phase_i == PHASE_W'(FRAME_BITS)); // R8
endmodule

bind serial_clock_slave serial_clock_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_i      (ce_i),
  .sclk_i    (sclk_i),
  .sdo_o     (sdo_o),
  .irq_clr_o (irq_clr_o),
  .phase_i   (phase_w),
  .cmd_i     (cmd_w)
);

// File: tb/serial_clock_slave_tb_top.sv
`timescale 1ns/1ps
module serial_clock_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [5:0] sec = '0, mnt = '0;
  logic [4:0] hour = '0, day = 5'd1;
  logic [3:0] month = 4'd1;
  logic [6:0] year = '0;
  logic sdo, irq_clr;

  int n_cmp = 0, n_bad = 0, irq_cnt = 0;
  bit done = 1'b0;
  logic [7:0] model [32];

  always #2.5 clk = ~clk;

  serial_clock_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
    .sec_i(sec), .min_i(mnt), .hour_i(hour), .day_i(day), .month_i(month),
    .year_i(year), .sdo_o(sdo), .irq_clr_o(irq_clr)
  );

  always @(posedge clk) if (irq_clr) irq_cnt++;

  function automatic logic [7:0] exp_init(int i);
    return 8'((i * 37) % 256) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] exp_time(logic [7:0] c);
    case (c)
      8'h20: return bcd(int'(sec));
      8'h21: return bcd(int'(mnt));
      8'h22: return bcd(int'(hour));
      8'h24: return bcd(int'(day));
      8'h25: return bcd(int'(month));
      8'h26: return bcd(int'(year));
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, int idx, inout logic [7:0] rd);
    @(negedge clk); sclk = 1'b1; sdi = b;
    @(negedge clk);
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (idx >= 8 && idx < 16) rd[15 - idx] = sdo;
  endtask

  task automatic xfer(logic [7:0] c, logic [7:0] v, int extra, output logic [7:0] rd);
    logic [15:0] w;
    w  = {c, v};
    rd = '0;
    @(negedge clk); ce = 1'b1;
    for (int i = 0; i < 16; i++) send_bit(w[15 - i], i, rd);
    for (int i = 0; i < extra; i++) send_bit(1'b1, 16 + i, rd);
    @(negedge clk); ce = 1'b0; sdi = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_byte(logic [7:0] c, output logic [7:0] rd);
    xfer(c, 8'h00, 0, rd);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 00 expected 01");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int unsigned seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 32; i++) model[i] = exp_init(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk("R9 sdo reset", {7'd0, sdo}, 8'h00);
    chk("R9 irq reset", {7'd0, irq_clr}, 8'h00);
    for (int i = 0; i < 32; i++) begin
      rd_byte(8'(i), r);
      chk("R9 R4 nv init", r, model[i]);
    end
    rd_byte(8'h30, r); chk("R9 R5 status", r, 8'h90);
    rd_byte(8'h31, r); chk("R5 control", r, 8'h00);

    // R7: write then read
    xfer(8'h85, 8'hC3, 0, r); model[5] = 8'hC3;
    rd_byte(8'h05, r); chk("R7 write 0x85", r, 8'hC3);
    xfer(8'h9F, 8'h01, 0, r); model[31] = 8'h01;
    rd_byte(8'h1F, r); chk("R7 write top", r, 8'h01);

    // R2: extra bits ignored
    xfer(8'h86, 8'h11, 5, r); model[6] = 8'h11;
    rd_byte(8'h06, r); chk("R2 extra bits", r, 8'h11);

    // R3: abort mid value byte
    begin
      logic [15:0] w;
      logic [7:0] dummy;
      w = 16'h87FF; dummy = '0;
      @(negedge clk); ce = 1'b1;
      for (int i = 0; i < 12; i++) send_bit(w[15 - i], i, dummy);
      @(negedge clk); ce = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R3 sdo after abort", {7'd0, sdo}, 8'h00);
    end
    rd_byte(8'h07, r); chk("R3 abort no write", r, model[7]);

    // R1: clocking with ce low
    begin
      logic [15:0] w;
      logic [7:0] dummy;
      w = 16'h88EE; dummy = '0;
      for (int i = 0; i < 16; i++) send_bit(w[15 - i], i, dummy);
    end
    rd_byte(8'h08, r); chk("R1 ce low ignored", r, model[8]);

    // R10: unrecognized commands
    xfer(8'hA0, 8'h55, 0, r); chk("R10 A0 sdo", r, 8'h00);
    rd_byte(8'h40, r); chk("R10 read 40", r, 8'h00);
    rd_byte(8'hFF, r); chk("R10 read FF", r, 8'h00);
    xfer(8'hB1, 8'hFB, 0, r);
    rd_byte(8'h30, r); chk("R8 no clear bit", r, 8'h90);
    chk("R8 no pulse", 8'(irq_cnt), 8'h00);
    rd_byte(8'h00, r); chk("R10 nv untouched", r, model[0]);

    // R6: time fields
    sec = 6'd59; mnt = 6'd0; hour = 5'd23; day = 5'd31; month = 4'd12; year = 7'd99;
    for (int c = 8'h20; c <= 8'h2F; c++) begin
      rd_byte(8'(c), r); chk("R6 time", r, exp_time(8'(c)));
    end

    // R8: status clear
    xfer(8'hB1, 8'h04, 0, r);
    rd_byte(8'h30, r); chk("R8 status cleared", r, 8'h80);
    chk("R8 one pulse", 8'(irq_cnt), 8'h01);
    rd_byte(8'h31, r); chk("R5 control after clear", r, 8'h00);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int op;
      int a;
      logic [7:0] v;
      op = int'($urandom_range(2, 0));
      a  = int'($urandom_range(31, 0));
      v  = 8'($urandom());
      if (op == 0) begin
        xfer(8'h80 + 8'(a), v, int'($urandom_range(3, 0)), r);
        model[a] = v;
      end else if (op == 1) begin
        rd_byte(8'(a), r); chk("R4 R7 random read", r, model[a]);
      end else begin
        sec = 6'($urandom_range(59, 0)); mnt = 6'($urandom_range(59, 0));
        hour = 5'($urandom_range(23, 0)); day = 5'($urandom_range(31, 1));
        month = 4'($urandom_range(12, 1)); year = 7'($urandom_range(99, 0));
        rd_byte(8'h20 + 8'(a % 8), r); chk("R6 random time", r, exp_time(8'h20 + 8'(a % 8)));
      end
    end
    for (int i = 0; i < 32; i++) begin
      rd_byte(8'(i), r); chk("R7 final sweep", r, model[i]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule